// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block takes received Ethernet frames one byte per cycle and stores each into host memory through a descriptor ring. When a frame starts, the engine fetches the current descriptor. It checks whether software has handed that descriptor to the hardware, then copies the frame bytes into the buffer the descriptor names. It then overwrites the descriptor's first word with a completion status that carries the length. Last, it moves the ring pointer forward, or back to the ring base when the descriptor marks the end of the ring.

Along the way the engine works out whether each frame is unicast, multicast or broadcast. It keeps 64-bit statistics counters and raises one-cycle event pulses that an interrupt controller can latch. A frame is refused when receive is disabled. A frame is dropped when it is too short or when no descriptor is available. All memory traffic goes through one word-wide request port with byte enables that waits for an acknowledge.

Top module: `rx_desc_wb`

## Requirements
- R1: If `rx_run` is low when the first byte of a frame is offered, the whole frame is consumed and discarded. No memory request is made, no counter changes and no event pulses.
- R2: A frame of fewer than 12 bytes pulses `evt_rx_done` and `evt_normal`. It leaves the descriptor word, `cur_desc` and all counters unchanged. A frame of exactly 12 bytes is accepted normally.
- R3: If bit 31 (ownership) of descriptor word 0 is clear, a frame of 12 bytes or more is drained without any memory write. `evt_buf_unavail` and `evt_abnormal` pulse, and `cur_desc` and the counters stay unchanged.
- R4: The frame bytes are written from the buffer address held in descriptor word 2 (offset 8) onward, little-endian within each 32-bit word. A final partial word uses byte enables, so bytes beyond the frame end keep their old value.
- R5: On success, descriptor word 0 is rewritten as ((length + 4) << 16) | 0x300. Bits 9 and 8 are set and every other bit is zero, which clears the ownership bit.
- R6: After a writeback, `cur_desc` returns to the ring base if bit 15 of descriptor word 1 (offset 4) is set. Otherwise it advances by 32. A pulse on `ring_load` sets both the ring base and `cur_desc` to `ring_base`.
- R7: A destination address of six 0xFF bytes is broadcast. Otherwise a first byte with bit 0 set is multicast. Anything else is unicast.
- R8: Each accepted frame adds 1 to `cnt_frames` and length + 4 to `cnt_bytes`. It also adds 1 to `cnt_mcast` or `cnt_bcast` according to its class. The counters are 64 bits wide and wrap silently.
- R9: Each accepted frame produces a single one-cycle pulse on `evt_rx_done` and on `evt_normal`, and none on the other two events.
- R10: A memory request keeps its address, direction, data and enables stable until `mem_ack`. For a read, `mem_rdata` is taken in the `mem_ack` cycle.
- R11: After reset the counters and `cur_desc` are zero, no event is pending and no memory request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_run | input | 1 | Receive enable, sampled at frame start |
| ring_load | input | 1 | Load ring base and current pointer |
| ring_base | input | AW | Descriptor ring base address |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of the frame |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| cur_desc | output | AW | Current descriptor address |
| evt_rx_done | output | 1 | Receive-complete event pulse |
| evt_normal | output | 1 | Normal summary event pulse |
| evt_buf_unavail | output | 1 | No-descriptor event pulse |
| evt_abnormal | output | 1 | Abnormal summary event pulse |
| cnt_frames | output | 64 | Accepted frame count |
| cnt_bytes | output | 64 | Reported byte count |
| cnt_mcast | output | 64 | Multicast frame count |
| cnt_bcast | output | 64 | Broadcast frame count |

## Verification
The hardest case to reach is a descriptor that software has not re-armed. The bench does not plant it directly. It walks a four-entry ring to its wrap point, so the engine's own completion word clears the ownership bit of the first descriptor, and the next frame finds it unavailable. The bench then re-arms that entry and checks that receive resumes. It also places a runt between accepted frames to show that neither the pointer nor the descriptor moves. Frame lengths are chosen to end in a partial word, so byte enables are exercised against a guard pattern in the buffer.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DROP,
    ST_RD_CTL,
    ST_RD_SIZE,
    ST_RD_BUF,
    ST_DATA,
    ST_FLUSH,
    ST_WB
  } rxwb_state_e;

  typedef enum logic [1:0] {
    CLS_UNI   = 2'd0,
    CLS_MULTI = 2'd1,
    CLS_BCAST = 2'd2
  } frame_class_e;

  localparam int OWN_BIT      = 31;
  localparam int WRAP_BIT     = 15;
  localparam int SIZE_OFS     = 4;
  localparam int BUF_OFS      = 8;
  localparam int DESC_BYTES   = 32;
  localparam int CRC_BYTES    = 4;
  localparam int RUNT_MIN     = 12;
  localparam int DA_BYTES     = 6;
  localparam logic [15:0] DONE_FLAGS = 16'h0300;

endpackage

// File: rtl/rxwb_classify.sv
module rxwb_classify
  import rxwb_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [LEN_W-1:0] idx,
  input  logic [7:0]       data,
  output frame_class_e     cls
);

  logic ones_q, ones_d;
  logic grp_q, grp_d;

  always_comb begin
    ones_d = ones_q;
    grp_d  = grp_q;
    if (clr) begin
      ones_d = 1'b1;
      grp_d  = 1'b0;
    end else if (take) begin
      if (idx == '0) grp_d = data[0];
      if (idx < LEN_W'(DA_BYTES)) ones_d = ones_q & (data == 8'hFF);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= 1'b1;
      grp_q  <= 1'b0;
    end else if (clr || take) begin
      ones_q <= ones_d;
      grp_q  <= grp_d;
    end
  end

  always_comb begin
    if (ones_q)     cls = CLS_BCAST;
    else if (grp_q) cls = CLS_MULTI;
    else            cls = CLS_UNI;
  end

  // R7
  bcast_is_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_q && !clr && $past(take) && $past(idx) == '0) |-> grp_q);

endmodule

// File: rtl/rxwb_pack.sv
module rxwb_pack #(
  parameter int LEN_W = 16,
  localparam int WIDX_W = LEN_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [7:0]        data,
  input  logic              last,
  input  logic              ack,
  output logic [31:0]       word,
  output logic [3:0]        be,
  output logic              pend,
  output logic [WIDX_W-1:0] widx
);

  logic [31:0]       word_q, word_d;
  logic [3:0]        be_q, be_d;
  logic [1:0]        lane_q, lane_d;
  logic              pend_q, pend_d;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic              upd;

  always_comb begin
    word_d = word_q;
    be_d   = be_q;
    lane_d = lane_q;
    pend_d = pend_q;
    widx_d = widx_q;
    if (clr) begin
      be_d   = '0;
      lane_d = '0;
      pend_d = 1'b0;
      widx_d = '0;
    end else if (ack && pend_q) begin
      pend_d = 1'b0;
      be_d   = '0;
      widx_d = widx_q + 1'b1;
    end else if (take) begin
      word_d[{lane_q, 3'b000} +: 8] = data;
      be_d[lane_q] = 1'b1;
      lane_d = lane_q + 1'b1;
      if (lane_q == 2'd3 || last) pend_d = 1'b1;
    end
  end

  assign upd = clr || (ack && pend_q) || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      be_q   <= '0;
      lane_q <= '0;
      pend_q <= 1'b0;
      widx_q <= '0;
    end else if (upd) begin
      word_q <= word_d;
      be_q   <= be_d;
      lane_q <= lane_d;
      pend_q <= pend_d;
      widx_q <= widx_d;
    end
  end

  assign word = word_q;
  assign be   = be_q;
  assign pend = pend_q;
  assign widx = widx_q;

  // R10
  take_while_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && pend_q));

  // R4
  pend_has_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (be_q != 4'b0000));

endmodule

// File: rtl/rxwb_stats.sv
module rxwb_stats
  import rxwb_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  input  frame_class_e     cls,
  input  logic [15:0]      add_len,
  output logic [CNT_W-1:0] cnt_frames,
  output logic [CNT_W-1:0] cnt_bytes,
  output logic [CNT_W-1:0] cnt_mcast,
  output logic [CNT_W-1:0] cnt_bcast
);

  logic [CNT_W-1:0] fr_q, fr_d, by_q, by_d, mc_q, mc_d, bc_q, bc_d;

  always_comb begin
    fr_d = fr_q + CNT_W'(1);
    by_d = by_q + CNT_W'(add_len);
    mc_d = (cls == CLS_MULTI) ? mc_q + CNT_W'(1) : mc_q;
    bc_d = (cls == CLS_BCAST) ? bc_q + CNT_W'(1) : bc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q <= '0;
      by_q <= '0;
      mc_q <= '0;
      bc_q <= '0;
    end else if (bump) begin
      fr_q <= fr_d;
      by_q <= by_d;
      mc_q <= mc_d;
      bc_q <= bc_d;
    end
  end

  assign cnt_frames = fr_q;
  assign cnt_bytes  = by_q;
  assign cnt_mcast  = mc_q;
  assign cnt_bcast  = bc_q;

  // R8
  class_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_q + bc_q) <= fr_q);

  // R8
  bytes_follow_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(by_q) |-> !$stable(fr_q));

endmodule

// File: rtl/rx_desc_wb.sv
module rx_desc_wb
  import rxwb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_run,
  input  logic             ring_load,
  input  logic [AW-1:0]    ring_base,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic [AW-1:0]    cur_desc,
  output logic             evt_rx_done,
  output logic             evt_normal,
  output logic             evt_buf_unavail,
  output logic             evt_abnormal,
  output logic [CNT_W-1:0] cnt_frames,
  output logic [CNT_W-1:0] cnt_bytes,
  output logic [CNT_W-1:0] cnt_mcast,
  output logic [CNT_W-1:0] cnt_bcast
);

  localparam int WIDX_W = LEN_W - 2;

  rxwb_state_e      state_q, state_d;
  logic [AW-1:0]    cur_q, cur_d, base_q, base_d, buf_q, buf_d;
  logic             owned_q, owned_d, wrap_q, wrap_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             ri_q, ri_d, nis_q, nis_d, ru_q, ru_d, ais_q, ais_d;

  logic             take, frame_clr, store, stat_bump, pk_ack;
  logic [31:0]      pk_word;
  logic [3:0]       pk_be;
  logic             pk_pend;
  logic [WIDX_W-1:0] pk_widx;
  logic [15:0]      rep_len;
  frame_class_e     cls;

  assign take      = in_valid && in_ready;
  assign frame_clr = (state_q == ST_IDLE) && in_valid;
  assign store     = take && owned_q && (state_q == ST_DATA);
  assign rep_len   = 16'(len_q) + 16'(CRC_BYTES);

  always_comb begin
    in_ready = 1'b0;
    case (state_q)
      ST_DROP: in_ready = 1'b1;
      ST_DATA: in_ready = !pk_pend;
      default: in_ready = 1'b0;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    base_d    = base_q;
    buf_d     = buf_q;
    owned_d   = owned_q;
    wrap_d    = wrap_q;
    len_d     = len_q;
    ri_d      = 1'b0;
    nis_d     = 1'b0;
    ru_d      = 1'b0;
    ais_d     = 1'b0;
    stat_bump = 1'b0;
    pk_ack    = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = '0;
    mem_be    = 4'hF;

    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          len_d   = '0;
          owned_d = 1'b0;
          wrap_d  = 1'b0;
          state_d = rx_run ? ST_RD_CTL : ST_DROP;
        end
      end
      ST_DROP: begin
        if (take && in_last) state_d = ST_IDLE;
      end
      ST_RD_CTL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          owned_d = mem_rdata[OWN_BIT];
          state_d = mem_rdata[OWN_BIT] ? ST_RD_SIZE : ST_DATA;
        end
      end
      ST_RD_SIZE: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + AW'(SIZE_OFS);
        if (mem_ack) begin
          wrap_d  = mem_rdata[WRAP_BIT];
          state_d = ST_RD_BUF;
        end
      end
      ST_RD_BUF: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + AW'(BUF_OFS);
        if (mem_ack) begin
          buf_d   = AW'(mem_rdata);
          state_d = ST_DATA;
        end
      end
      ST_DATA, ST_FLUSH: begin
        if (pk_pend) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = buf_q + AW'({pk_widx, 2'b00});
          mem_wdata = pk_word;
          mem_be    = pk_be;
          pk_ack    = mem_ack;
        end
        if (state_q == ST_DATA) begin
          if (take) begin
            len_d = len_q + 1'b1;
            if (in_last) state_d = ST_FLUSH;
          end
        end else if (!pk_pend) begin
          if (len_q < LEN_W'(RUNT_MIN)) begin
            ri_d    = 1'b1;
            nis_d   = 1'b1;
            state_d = ST_IDLE;
          end else if (!owned_q) begin
            ru_d    = 1'b1;
            ais_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_WB;
          end
        end
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {rep_len, DONE_FLAGS};
        if (mem_ack) begin
          cur_d     = wrap_q ? base_q : cur_q + AW'(DESC_BYTES);
          stat_bump = 1'b1;
          ri_d      = 1'b1;
          nis_d     = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (ring_load) begin
      base_d = ring_base;
      cur_d  = ring_base;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      base_q  <= '0;
      buf_q   <= '0;
      owned_q <= 1'b0;
      wrap_q  <= 1'b0;
      len_q   <= '0;
      ri_q    <= 1'b0;
      nis_q   <= 1'b0;
      ru_q    <= 1'b0;
      ais_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      base_q  <= base_d;
      buf_q   <= buf_d;
      owned_q <= owned_d;
      wrap_q  <= wrap_d;
      len_q   <= len_d;
      ri_q    <= ri_d;
      nis_q   <= nis_d;
      ru_q    <= ru_d;
      ais_q   <= ais_d;
    end
  end

  rxwb_pack #(.LEN_W(LEN_W)) u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (frame_clr),
    .take  (store),
    .data  (in_data),
    .last  (in_last),
    .ack   (pk_ack),
    .word  (pk_word),
    .be    (pk_be),
    .pend  (pk_pend),
    .widx  (pk_widx)
  );

  rxwb_classify #(.LEN_W(LEN_W)) u_cls (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (frame_clr),
    .take  (take && state_q == ST_DATA),
    .idx   (len_q),
    .data  (in_data),
    .cls   (cls)
  );

  rxwb_stats #(.CNT_W(CNT_W)) u_stats (
    .clk        (clk),
    .rst_n      (rst_n),
    .bump       (stat_bump),
    .cls        (cls),
    .add_len    (rep_len),
    .cnt_frames (cnt_frames),
    .cnt_bytes  (cnt_bytes),
    .cnt_mcast  (cnt_mcast),
    .cnt_bcast  (cnt_bcast)
  );

  assign cur_desc        = cur_q;
  assign evt_rx_done     = ri_q;
  assign evt_normal      = nis_q;
  assign evt_buf_unavail = ru_q;
  assign evt_abnormal    = ais_q;

  // R1
  drop_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP) |-> !mem_req);

  // R2
  runt_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_bump |-> (len_q >= LEN_W'(RUNT_MIN)));

  // R3
  ru_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_buf_unavail |-> (!evt_rx_done && evt_abnormal));

  // R3
  unowned_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> owned_q);

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cur_desc) && !$past(ring_load)) |->
      (cur_desc == $past(cur_desc) + AW'(DESC_BYTES) || cur_desc == base_q));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !ring_load) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_done |=> !evt_rx_done);

endmodule

// File: tb/rx_desc_wb_tb.sv
module rx_desc_wb_tb;

  logic        clk, rst_n, rx_run, ring_load;
  logic [31:0] ring_base;
  logic        in_valid, in_last, in_ready;
  logic [7:0]  in_data;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [31:0] cur_desc;
  logic        evt_rx_done, evt_normal, evt_buf_unavail, evt_abnormal;
  logic [63:0] cnt_frames, cnt_bytes, cnt_mcast, cnt_bcast;

  rx_desc_wb u_dut (
    .clk(clk), .rst_n(rst_n), .rx_run(rx_run), .ring_load(ring_load),
    .ring_base(ring_base), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cur_desc(cur_desc), .evt_rx_done(evt_rx_done), .evt_normal(evt_normal),
    .evt_buf_unavail(evt_buf_unavail), .evt_abnormal(evt_abnormal),
    .cnt_frames(cnt_frames), .cnt_bytes(cnt_bytes),
    .cnt_mcast(cnt_mcast), .cnt_bcast(cnt_bcast)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one-cycle acknowledge, byte-enabled writes
  logic [31:0] mem [0:1023];
  int mem_writes = 0;
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem_writes <= mem_writes + 1;
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // event pulse counters
  int n_ri = 0, n_nis = 0, n_ru = 0, n_ais = 0;
  always @(posedge clk) if (rst_n) begin
    n_ri  <= n_ri  + int'(evt_rx_done);
    n_nis <= n_nis + int'(evt_normal);
    n_ru  <= n_ru  + int'(evt_buf_unavail);
    n_ais <= n_ais + int'(evt_abnormal);
  end

  // per-clock check while a refused frame is in flight
  logic drop_win = 1'b0;
  always @(negedge clk) if (drop_win) begin
    check("R1 no memory request", mem_req, 1'b0);
    check("R1 no event", {evt_rx_done, evt_normal, evt_buf_unavail, evt_abnormal}, 4'b0);
  end

  // reference model state
  logic [7:0]  fq[$];
  logic [63:0] m_frames = 0, m_bytes = 0, m_mc = 0, m_bc = 0;
  int s_ri, s_nis, s_ru, s_ais;

  function automatic logic [7:0] rd_byte(input int a);
    return mem[a >> 2][(a & 3) * 8 +: 8];
  endfunction

  task automatic arm(input int d, input int bufa, input logic wrap);
    mem[d >> 2]       = 32'h8000_0000;
    mem[(d + 4) >> 2] = {16'h0, wrap, 15'd2000};
    mem[(d + 8) >> 2] = bufa;
    for (int i = 0; i < 32; i++) mem[(bufa >> 2) + i] = 32'hA5A5_A5A5;
  endtask

  task automatic build(input int n, input logic [47:0] da, input int seed);
    fq.delete();
    for (int i = 0; i < n; i++)
      if (i < 6) fq.push_back(da[47 - 8*i -: 8]);
      else fq.push_back(8'(seed + i));
  endtask

  task automatic send();
    s_ri = n_ri; s_nis = n_nis; s_ru = n_ru; s_ais = n_ais;
    for (int i = 0; i < fq.size(); i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fq[i];
      in_last  = (i == fq.size() - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  task automatic check_counts(input string req);
    check({req, " frames"}, cnt_frames, m_frames);
    check({req, " bytes"},  cnt_bytes,  m_bytes);
    check({req, " mcast"},  cnt_mcast,  m_mc);
    check({req, " bcast"},  cnt_bcast,  m_bc);
  endtask

  task automatic check_events(input string req, input int ri, input int ru);
    check({req, " events"},
          {8'(n_ri - s_ri), 8'(n_nis - s_nis), 8'(n_ru - s_ru), 8'(n_ais - s_ais)},
          {8'(ri), 8'(ri), 8'(ru), 8'(ru)});
  endtask

  // accepted frame: model R4..R9
  task automatic expect_ok(input int d, input int bufa, input int next_ptr);
    int n, bad;
    logic bc, mc;
    n = fq.size();
    bad = 0;
    for (int i = 0; i < n; i++) if (rd_byte(bufa + i) !== fq[i]) bad++;
    check("R4 buffer bytes", bad, 0);
    check("R4 byte past end untouched", rd_byte(bufa + n), 8'hA5);
    check("R5 completion word", mem[d >> 2], {16'(n + 4), 16'h0300});
    check("R6 pointer", cur_desc, next_ptr);
    bc = (fq[0] == 8'hFF && fq[1] == 8'hFF && fq[2] == 8'hFF &&
          fq[3] == 8'hFF && fq[4] == 8'hFF && fq[5] == 8'hFF);
    mc = !bc && fq[0][0];
    m_frames++;
    m_bytes += 64'(n + 4);
    if (mc) m_mc++;
    if (bc) m_bc++;
    check_counts("R7 R8");
    check_events("R9", 1, 0);
  endtask

  initial begin
    rst_n = 1'b0; rx_run = 1'b0; ring_load = 1'b0; ring_base = '0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    mem_ack = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 counters", cnt_frames | cnt_bytes | cnt_mcast | cnt_bcast, 0);
    check("R11 pointer", cur_desc, 0);
    check("R11 idle outputs",
          {mem_req, in_ready, evt_rx_done, evt_normal, evt_buf_unavail, evt_abnormal}, 6'b0);

    arm(32'h100, 32'h400, 1'b0);
    arm(32'h120, 32'h500, 1'b0);
    arm(32'h140, 32'h600, 1'b0);
    arm(32'h160, 32'h700, 1'b1);
    ring_base = 32'h100;
    ring_load = 1'b1;
    @(negedge clk);
    ring_load = 1'b0;
    check("R6 ring load", cur_desc, 32'h100);

    // R1 refused while receive is off
    build(20, 48'h02AABBCCDDEE, 3);
    drop_win = 1'b1;
    send();
    drop_win = 1'b0;
    check("R1 descriptor untouched", mem[32'h100 >> 2], 32'h8000_0000);
    check("R1 no writes", mem_writes, 0);
    check("R1 pointer", cur_desc, 32'h100);
    check_counts("R1");

    rx_run = 1'b1;
    build(20, 48'h02AABBCCDDEE, 7);                 // unicast
    send();
    expect_ok(32'h100, 32'h400, 32'h120);

    build(61, 48'hFFFFFFFFFFFF, 9);                 // broadcast, partial word
    send();
    expect_ok(32'h120, 32'h500, 32'h140);

    // R2 runt
    build(11, 48'hFFFFFFFFFFFF, 1);
    send();
    check("R2 descriptor untouched", mem[32'h140 >> 2], 32'h8000_0000);
    check("R2 pointer", cur_desc, 32'h140);
    check_counts("R2");
    check_events("R2", 1, 0);

    build(13, 48'hFFFFFFFFFFFE, 4);                 // multicast, not broadcast
    send();
    expect_ok(32'h140, 32'h600, 32'h160);

    build(12, 48'h01005E000001, 5);                 // R2 boundary, R6 wrap
    send();
    expect_ok(32'h160, 32'h700, 32'h100);

    // R3 descriptor at 0x100 now owned by software
    build(30, 48'h02AABBCCDDEE, 2);
    send();
    check("R3 pointer", cur_desc, 32'h100);
    check("R3 descriptor untouched", mem[32'h100 >> 2], {16'd24, 16'h0300});
    check_counts("R3");
    check_events("R3", 0, 1);

    arm(32'h100, 32'h400, 1'b0);
    build(16, 48'h0600000000AB, 6);
    send();
    expect_ok(32'h100, 32'h400, 32'h120);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule